// File: doc/BRIEF.md
# Serial EEPROM Status Register and Write Guard

This block keeps the status byte of a serial EEPROM and decides, cycle by cycle, whether the command engine may write the array or the status register. It holds a busy flag and a write-enable latch. It also holds three bits that are retained across write cycles: a hardware-protect enable and a two-bit block-protect code. These bits are combined with the write-protect pin and the address the engine is about to program.

The command engine feeds the block single-cycle strobes. These mark a write-enable or write-disable opcode, a received status data byte, the start of an array write cycle, and the end of any internal write cycle. The engine also drives the chip-select level and the candidate write address. The block returns the status byte, which the engine shifts out on a status read, and two permit lines. A request that is not permitted is dropped with no state change and no error flag.

A status write is held pending until chip select rises. While chip select is still low, the write is cancelled if the protect pin drops with the hardware-protect enable set. Once the internal cycle has begun, the pin no longer matters.

Top module: `eeprom_wprot`

## Requirements
- R1: The status byte reads {hw-protect enable, 0, 0, 0, block-protect high, block-protect low, write-enable latch, busy} from bit 7 down to bit 0, and is 0x00 after reset.
- R2: A write-enable strobe sets the latch (bit 1), and a write-disable strobe clears it. If both come in the same cycle, the enable wins.
- R3: Busy (bit 0) rises one cycle after an accepted array-start strobe, or after chip select rises with a status write pending. It falls one cycle after a write-done strobe, and the latch clears in that same cycle.
- R4: A status write can change only bits 7, 3 and 2. The new values appear together with busy falling at the end of that write cycle, and those bits change at no other time.
- R5: With ADDR_BITS significant address bits, the top two address bits pick a quarter. Block-protect code 00 protects no quarter, 01 protects quarter 3, 10 protects quarters 2 and 3, and 11 protects all quarters.
- R6: With the latch clear, both permits are low. A refused array start or status write changes nothing: busy stays 0 and the status byte is unchanged.
- R7: With the latch set and the block idle, the array permit is high exactly for unprotected addresses. The status permit is high unless bit 7 is 1 and wp_n is low.
- R8: A pending status write is dropped if wp_n is low while cs_n is low and bit 7 is 1. After chip select has risen and the cycle has started, wp_n has no effect on the values written.
- R9: While busy, both permits are low, and write-enable, write-disable, status-write and array-start strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select level, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_stb | input | 1 | Write-enable opcode seen |
| wrdi_stb | input | 1 | Write-disable opcode seen |
| wrsr_stb | input | 1 | Status data byte received |
| wrsr_byte | input | 8 | Status data byte |
| chk_addr | input | ADDR_BITS | Candidate array write address |
| arr_start_stb | input | 1 | Array write cycle start request |
| wr_done_stb | input | 1 | Internal write cycle finished |
| status_byte | output | 8 | Status register contents |
| arr_permit | output | 1 | Array write at chk_addr allowed now |
| sr_permit | output | 1 | Status write allowed now |

## Verification
The bench builds the block with ADDR_BITS set to 11. This moves the quarter boundaries to 0x200, 0x400 and 0x600 and checks that the top-bit selection follows the parameter rather than a fixed width. The sweeps walk every quarter under every block-protect code, with the hardware-protect enable both set and clear and the pin at both levels. The sequences also place a protect-pin drop before and after the chip-select rise of a status write.

// File: rtl/eeprom_wprot.sv
module eeprom_wprot #(
  parameter int ADDR_BITS = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cs_n,
  input  logic                 wp_n,
  input  logic                 wren_stb,
  input  logic                 wrdi_stb,
  input  logic                 wrsr_stb,
  input  logic [7:0]           wrsr_byte,
  input  logic [ADDR_BITS-1:0] chk_addr,
  input  logic                 arr_start_stb,
  input  logic                 wr_done_stb,
  output logic [7:0]           status_byte,
  output logic                 arr_permit,
  output logic                 sr_permit
);
  localparam int TOP = ADDR_BITS - 1;

  logic       wel, busy, sr_kind, wpen, pend, cs_q, nxt_wpen;
  logic [1:0] bp, nxt_bp, seg;
  logic       blocked, hw_lock, cs_rise;

  assign seg     = chk_addr[TOP -: 2];
  assign hw_lock = wpen & ~wp_n;
  assign cs_rise = cs_n & ~cs_q;

  always_comb begin
    case (bp)
      2'b00:   blocked = 1'b0;
      2'b01:   blocked = &seg;
      2'b10:   blocked = seg[1];
      default: blocked = 1'b1;
    endcase
  end

  assign arr_permit  = wel & ~busy & ~blocked;
  assign sr_permit   = wel & ~busy & ~hw_lock;
  assign status_byte = {wpen, 3'b000, bp, wel, busy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel      <= 1'b0;
      busy     <= 1'b0;
      sr_kind  <= 1'b0;
      wpen     <= 1'b0;
      bp       <= 2'b00;
      pend     <= 1'b0;
      nxt_wpen <= 1'b0;
      nxt_bp   <= 2'b00;
      cs_q     <= 1'b1;
    end else begin
      cs_q <= cs_n;
      if (busy) begin
        if (wr_done_stb) begin
          busy <= 1'b0;
          wel  <= 1'b0;
          if (sr_kind) begin
            wpen <= nxt_wpen;
            bp   <= nxt_bp;
          end
        end
      end else begin
        if (wren_stb)      wel <= 1'b1;
        else if (wrdi_stb) wel <= 1'b0;

        if (cs_rise && pend) begin
          busy    <= 1'b1;
          sr_kind <= 1'b1;
        end else if (arr_start_stb && arr_permit) begin
          busy    <= 1'b1;
          sr_kind <= 1'b0;
        end

        if (cs_rise) pend <= 1'b0;
        else if (!cs_n && hw_lock) pend <= 1'b0;
        else if (wrsr_stb && sr_permit) begin
          pend     <= 1'b1;
          nxt_wpen <= wrsr_byte[7];
          nxt_bp   <= wrsr_byte[3:2];
        end
      end
    end
  end

  // R3
  wel_drop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status_byte[0]) |-> !status_byte[1]);

  // R4
  nv_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_done_stb |=> $stable(status_byte[7:2]));

  // R6
  refused_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_start_stb && !arr_permit && !status_byte[0] && !(cs_rise && pend) |=> !status_byte[0]);

  // R6
  refused_sr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend && wrsr_stb && !sr_permit |=> !pend);

  // R8
  wp_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend && !cs_n && !wp_n && wpen && !busy |=> !pend && !busy);

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[0] && !wr_done_stb && (wren_stb || wrdi_stb) |=> $stable(status_byte[1]));
endmodule

// File: tb/eeprom_wprot_test.sv
module eeprom_wprot_test;
  localparam int PERIOD = 10;
  localparam int AB = 11;

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, wp_n = 1'b1;
  logic wren_stb = 0, wrdi_stb = 0, wrsr_stb = 0, arr_start_stb = 0, wr_done_stb = 0;
  logic [7:0] wrsr_byte = 8'h00;
  logic [AB-1:0] chk_addr = '0;
  logic [7:0] status_byte;
  logic arr_permit, sr_permit;

  int checks = 0, errors = 0;
  bit finished = 0;
  string phase = "R1 reset";

  int m_wel = 0, m_busy = 0, m_kind = 0, m_wpen = 0, m_bp = 0;
  int m_pend = 0, m_pw = 0, m_pbp = 0, m_csq = 1;

  always #(PERIOD/2) clk = ~clk;

  eeprom_wprot #(.ADDR_BITS(AB)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n),
    .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb), .wrsr_byte(wrsr_byte),
    .chk_addr(chk_addr), .arr_start_stb(arr_start_stb), .wr_done_stb(wr_done_stb),
    .status_byte(status_byte), .arr_permit(arr_permit), .sr_permit(sr_permit));

  function automatic int exp_arr();
    int q = int'(chk_addr) / (1 << (AB - 2));
    int prot = (m_bp == 3) || (m_bp == 2 && q >= 2) || (m_bp == 1 && q == 3);
    return (m_wel && !m_busy && !prot) ? 1 : 0;
  endfunction

  function automatic int exp_sr();
    return (m_wel && !m_busy && !(m_wpen && !wp_n)) ? 1 : 0;
  endfunction

  function automatic int exp_status();
    return m_wpen * 128 + m_bp * 4 + m_wel * 2 + m_busy;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wel = 0; m_busy = 0; m_kind = 0; m_wpen = 0; m_bp = 0;
      m_pend = 0; m_pw = 0; m_pbp = 0; m_csq = 1;
    end else begin
      automatic int ea = exp_arr();
      automatic int es = exp_sr();
      automatic int rise = (cs_n && !m_csq) ? 1 : 0;
      automatic int lock = (m_wpen && !wp_n) ? 1 : 0;
      if (m_busy) begin
        if (wr_done_stb) begin
          m_busy = 0; m_wel = 0;
          if (m_kind) begin m_wpen = m_pw; m_bp = m_pbp; end
        end
      end else begin
        if (wren_stb) m_wel = 1; else if (wrdi_stb) m_wel = 0;
        if (rise && m_pend) begin m_busy = 1; m_kind = 1; end
        else if (arr_start_stb && ea) begin m_busy = 1; m_kind = 0; end
        if (rise) m_pend = 0;
        else if (!cs_n && lock) m_pend = 0;
        else if (wrsr_stb && es) begin
          m_pend = 1; m_pw = wrsr_byte[7]; m_pbp = int'(wrsr_byte[3:2]);
        end
      end
      m_csq = cs_n;
    end
  end

  task automatic check(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", phase, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      check("status", int'(status_byte), exp_status());
      check("arr_permit", int'(arr_permit), exp_arr());
      check("sr_permit", int'(sr_permit), exp_sr());
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic sr_write(input logic [7:0] v);
    cs_n = 1'b0; tick();
    wrsr_byte = v; pulse(wrsr_stb);
    cs_n = 1'b1; tick();
  endtask

  task automatic finish_cycle();
    tick(2); pulse(wr_done_stb); tick();
  endtask

  task automatic sweep();
    for (int q = 0; q < 4; q++) begin
      chk_addr = AB'(q * (1 << (AB - 2)));                 tick();
      chk_addr = AB'(q * (1 << (AB - 2)) + (1 << (AB - 2)) - 1); tick();
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog all actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    tick(3); rst_n = 1'b1; tick();
    phase = "R1 reset value";
    check("status after reset", int'(status_byte), 0);

    phase = "R6 refused without latch";
    chk_addr = 11'h010; pulse(arr_start_stb); tick();
    check("busy stays low", int'(status_byte[0]), 0);
    sr_write(8'h8C); tick(2);
    check("status unchanged", int'(status_byte), 0);

    phase = "R2 latch set clear";
    pulse(wren_stb); tick();
    check("latch set", int'(status_byte[1]), 1);
    pulse(wrdi_stb); tick();
    check("latch clear", int'(status_byte[1]), 0);
    wren_stb = 1; wrdi_stb = 1; tick(); wren_stb = 0; wrdi_stb = 0; tick();
    check("enable wins", int'(status_byte[1]), 1);

    phase = "R3 array cycle";
    chk_addr = 11'h005; pulse(arr_start_stb);
    check("busy rises", int'(status_byte[0]), 1);
    phase = "R9 busy ignores";
    pulse(wrdi_stb); pulse(arr_start_stb); sr_write(8'h8C);
    check("latch held busy", int'(status_byte[1]), 1);
    phase = "R3 array cycle end";
    pulse(wr_done_stb);
    check("busy falls latch clears", int'(status_byte[1:0]), 0);

    phase = "R4 status write bits";
    pulse(wren_stb); sr_write(8'hFF);
    check("busy during status write", int'(status_byte[0]), 1);
    finish_cycle();
    check("only 7,3,2 written", int'(status_byte), 8'h8C);

    phase = "R5 R7 protect map";
    for (int code = 0; code < 4; code++) begin
      pulse(wren_stb); sr_write(8'(code * 4)); finish_cycle();
      pulse(wren_stb); sweep();
      wp_n = 1'b0; sweep(); wp_n = 1'b1;
      pulse(wrdi_stb);
    end

    phase = "R7 hw lock";
    pulse(wren_stb); sr_write(8'h84); finish_cycle();
    pulse(wren_stb); wp_n = 1'b0; tick();
    check("status permit low", int'(sr_permit), 0);
    chk_addr = 11'h100; tick();
    check("low quarter writable", int'(arr_permit), 1);
    sr_write(8'h00); tick(2);
    check("locked write ignored", int'(status_byte), 8'h86);
    wp_n = 1'b1; tick();

    phase = "R8 wp drop cancels";
    cs_n = 1'b0; tick(); wrsr_byte = 8'h00; pulse(wrsr_stb);
    wp_n = 1'b0; tick(); wp_n = 1'b1; cs_n = 1'b1; tick(3);
    check("no cycle started", int'(status_byte), 8'h86);

    phase = "R8 wp after start";
    sr_write(8'h08);
    wp_n = 1'b0; finish_cycle(); wp_n = 1'b1; tick();
    check("write completed", int'(status_byte), 8'h08);

    phase = "R8 wp ignored when enable off";
    pulse(wren_stb); cs_n = 1'b0; tick(); wrsr_byte = 8'h04; pulse(wrsr_stb);
    wp_n = 1'b0; tick(); cs_n = 1'b1; tick(); wp_n = 1'b1; finish_cycle();
    check("write kept", int'(status_byte), 8'h04);

    tick(2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule